// File: doc/BRIEF.md
# Circulating-Word Time and Channel Selector

This block picks one word out of a bank of memory channels whose contents circulate in lockstep. The upper address bits choose the channel and drive one select line per channel. The lower address bits name a word position. That position is compared with a free-running position counter, which tracks the word now at the output gate of every channel.

The counter advances on a once-per-minor-cycle timing strobe (`t2_i`). A second strobe (`t0_i`) samples the comparison. When the positions agree and a memory operation is enabled, the `t0_i` strobe opens a time-select window. The next `t0_i` strobe closes it, so the window lasts exactly one minor cycle.

The window is then steered to a read-timing output or a write-timing output. During a write it also blocks the recirculation path of the selected channel for that one word time.

Top module: `dlsel_top`

## Requirements
- R1: The position counter `pos_o` is 0 after reset and increases by one, modulo 4, at each clock edge where `t2_i` is high. It holds when `t2_i` is low.
- R2: While `mem_en_i` is high, `chan_sel_o` has exactly one bit set: bit `addr_i[3:2]`.
- R3: While `mem_en_i` is low, `chan_sel_o` is all zero.
- R4: At an edge where `t0_i` is high, `tsel_o` is low, `mem_en_i` is high and `addr_i[1:0]` equals `pos_o`, `tsel_o` becomes high. If the positions differ, `tsel_o` stays low.
- R5: While `mem_en_i` is low, a `t0_i` strobe never sets `tsel_o`, even when the positions match.
- R6: While `tsel_o` is high, the next `t0_i` strobe clears it, whatever the comparison shows. Without a `t0_i` strobe, `tsel_o` keeps its value, including across `t2_i` strobes.
- R7: `rd_tsel_o` is high exactly when `tsel_o` and `rd_en_i` are high and `wr_en_i` is low.
- R8: `wr_tsel_o` is high exactly when `tsel_o` and `wr_en_i` are high and `rd_en_i` is low.
- R9: When `rd_en_i` and `wr_en_i` are both high, neither `rd_tsel_o` nor `wr_tsel_o` is high.
- R10: Bit c of `recirc_block_o` is high exactly when `wr_tsel_o` is high and `chan_sel_o[c]` is high. Otherwise the whole vector is zero.
- R11: While `rst_ni` is low, `tsel_o` and `pos_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Word address: [3:2] channel, [1:0] word position |
| t0_i | input | 1 | Per-minor-cycle strobe that sets or clears the window |
| t2_i | input | 1 | Per-minor-cycle strobe that advances the counter |
| mem_en_i | input | 1 | A memory operation is in progress |
| rd_en_i | input | 1 | The operation reads from memory |
| wr_en_i | input | 1 | The operation writes to memory |
| pos_o | output | 2 | Word position now at the channel outputs |
| chan_sel_o | output | 4 | One-hot channel select |
| tsel_o | output | 1 | Time-select window |
| rd_tsel_o | output | 1 | Read timing window |
| wr_tsel_o | output | 1 | Write timing window |
| recirc_block_o | output | 4 | Per-channel recirculation block during a write |

## Verification
`pos_o` and `tsel_o` are registered. Each one changes at the first rising edge where its strobe is high, so the bench reads it one edge after the strobe is driven. The channel selects, the read and write windows and the recirculation block are combinational from `tsel_o` and the inputs. They are due in the same cycle in which an enable changes.

All inputs are driven on the falling edge, and all outputs are sampled on the falling edge. A sample therefore always sees the state after the preceding rising edge, and never a value caught in transition.

// File: rtl/dlsel_pkg.sv
package dlsel_pkg;
  localparam int unsigned CH_BITS_DEF  = 2;
  localparam int unsigned POS_BITS_DEF = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_CLASH = 2'b11
  } xfer_kind_e;

  function automatic xfer_kind_e classify(input logic rd, input logic wr);
    return xfer_kind_e'({wr, rd});
  endfunction
endpackage

// File: rtl/dlsel_pos_ctr.sv
module dlsel_pos_ctr #(
  parameter int unsigned POS_BITS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  output logic [POS_BITS-1:0] pos_o
);
  logic [POS_BITS-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (step_i) pos_q <= pos_q + POS_BITS'(1);
  end

  assign pos_o = pos_q;

  assert_pos_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> pos_q == $past(pos_q) + POS_BITS'(1));
  assert_pos_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q));
endmodule

// File: rtl/dlsel_chan_dec.sv
module dlsel_chan_dec #(
  parameter int unsigned CH_BITS = 2,
  localparam int unsigned NUM_CH = 1 << CH_BITS
) (
  input  logic [CH_BITS-1:0] chan_i,
  input  logic               en_i,
  output logic [NUM_CH-1:0]  sel_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_line
    assign sel_o[g] = en_i && (chan_i == CH_BITS'(g));
  end
endmodule

// File: rtl/dlsel_time_gate.sv
module dlsel_time_gate
  import dlsel_pkg::*;
#(
  parameter int unsigned POS_BITS = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                t0_i,
  input  logic [POS_BITS-1:0] word_i,
  input  logic [POS_BITS-1:0] pos_i,
  input  logic                mem_en_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  output logic                tsel_o,
  output logic                rd_tsel_o,
  output logic                wr_tsel_o
);
  logic [POS_BITS-1:0] miss;
  logic                coincide;
  logic                tsel_q;
  xfer_kind_e          kind;

  // per-bit disagreement lines; coincidence is the absence of all of them
  for (genvar b = 0; b < POS_BITS; b++) begin : g_cmp
    assign miss[b] = word_i[b] ^ pos_i[b];
  end
  assign coincide = ~|miss;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tsel_q <= 1'b0;
    else if (t0_i && tsel_q)              tsel_q <= 1'b0;
    else if (t0_i && coincide && mem_en_i) tsel_q <= 1'b1;
  end

  assign kind      = classify(rd_en_i, wr_en_i);
  assign tsel_o    = tsel_q;
  assign rd_tsel_o = tsel_q && (kind == OP_READ);
  assign wr_tsel_o = tsel_q && (kind == OP_WRITE);

  assert_open_on_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t0_i && !tsel_q && coincide && mem_en_i) |=> tsel_q);
  assert_open_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tsel_q) |-> $past(t0_i && coincide && mem_en_i));
  assert_close_next_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t0_i && tsel_q) |=> !tsel_q);
  assert_hold_no_t0_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t0_i |=> $stable(tsel_q));
  assert_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_tsel_o && wr_tsel_o));
endmodule

// File: rtl/dlsel_top.sv
module dlsel_top
  import dlsel_pkg::*;
#(
  parameter int unsigned CH_BITS  = CH_BITS_DEF,
  parameter int unsigned POS_BITS = POS_BITS_DEF,
  localparam int unsigned NUM_CH  = 1 << CH_BITS,
  localparam int unsigned ADDR_W  = CH_BITS + POS_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                t0_i,
  input  logic                t2_i,
  input  logic                mem_en_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  output logic [POS_BITS-1:0] pos_o,
  output logic [NUM_CH-1:0]   chan_sel_o,
  output logic                tsel_o,
  output logic                rd_tsel_o,
  output logic                wr_tsel_o,
  output logic [NUM_CH-1:0]   recirc_block_o
);
  logic [POS_BITS-1:0] pos;

  dlsel_pos_ctr #(.POS_BITS(POS_BITS)) u_pos (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(t2_i),
    .pos_o (pos)
  );

  dlsel_chan_dec #(.CH_BITS(CH_BITS)) u_dec (
    .chan_i(addr_i[ADDR_W-1:POS_BITS]),
    .en_i  (mem_en_i),
    .sel_o (chan_sel_o)
  );

  dlsel_time_gate #(.POS_BITS(POS_BITS)) u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .t0_i     (t0_i),
    .word_i   (addr_i[POS_BITS-1:0]),
    .pos_i    (pos),
    .mem_en_i (mem_en_i),
    .rd_en_i  (rd_en_i),
    .wr_en_i  (wr_en_i),
    .tsel_o   (tsel_o),
    .rd_tsel_o(rd_tsel_o),
    .wr_tsel_o(wr_tsel_o)
  );

  // recirculation of the written channel is held off for the window
  for (genvar c = 0; c < NUM_CH; c++) begin : g_blk
    assign recirc_block_o[c] = chan_sel_o[c] && wr_tsel_o;
  end

  assign pos_o = pos;

  assert_sel_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chan_sel_o) == (mem_en_i ? 1 : 0));
  assert_sel_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_en_i |-> chan_sel_o == '0);
  assert_block_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recirc_block_o != '0) |-> (wr_tsel_o && $onehot0(recirc_block_o)));
  assert_reset_R11: assert property (@(posedge clk_i)
    !rst_ni |-> (!tsel_o && pos_o == '0));
endmodule

// File: tb/dlsel_top_bench.sv
`timescale 1ns/1ps
module dlsel_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       t0 = 1'b0, t2 = 1'b0, mem_en = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] pos;
  logic [3:0] chan_sel, rblk;
  logic       tsel, rd_ts, wr_ts;

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0] exp_pos = '0;

  always #4 clk = ~clk;

  dlsel_top u_dlsel_top (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .t0_i(t0), .t2_i(t2),
    .mem_en_i(mem_en), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .pos_o(pos), .chan_sel_o(chan_sel), .tsel_o(tsel),
    .rd_tsel_o(rd_ts), .wr_tsel_o(wr_ts), .recirc_block_o(rblk)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_t0();
    @(negedge clk) t0 = 1'b1;
    @(negedge clk) t0 = 1'b0;
  endtask

  task automatic pulse_t2();
    @(negedge clk) t2 = 1'b1;
    @(negedge clk) t2 = 1'b0;
    exp_pos = exp_pos + 2'd1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R11 tsel in reset", 32'(tsel), 0);
    check("R11 pos in reset", 32'(pos), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R3 sel idle", 32'(chan_sel), 0);
  endtask

  task automatic t_counter();
    for (int k = 0; k < 5; k++) begin
      pulse_t2();
      check("R1 pos step", 32'(pos), 32'(exp_pos));
    end
    repeat (3) @(negedge clk);
    check("R1 pos hold", 32'(pos), 32'(exp_pos));
  endtask

  task automatic t_decode();
    mem_en = 1'b1;
    for (int c = 0; c < 4; c++) begin
      addr = {2'(c), 2'd0};
      @(negedge clk);
      check("R2 onehot", 32'(chan_sel), 32'(1) << c);
    end
    mem_en = 1'b0;
    @(negedge clk);
    check("R3 sel off", 32'(chan_sel), 0);
  endtask

  task automatic t_window_gating();
    mem_en = 1'b1; rd_en = 1'b0; wr_en = 1'b0;
    addr = {2'd2, exp_pos};
    pulse_t0();
    check("R4 open on match", 32'(tsel), 1);
    check("R7 no rd w/o enable", 32'(rd_ts), 0);
    check("R10 no block idle", 32'(rblk), 0);
    rd_en = 1'b1; @(negedge clk);
    check("R7 rd window", 32'(rd_ts), 1);
    check("R8 wr off on read", 32'(wr_ts), 0);
    check("R10 no block on read", 32'(rblk), 0);
    rd_en = 1'b0; wr_en = 1'b1; @(negedge clk);
    check("R8 wr window", 32'(wr_ts), 1);
    check("R7 rd off on write", 32'(rd_ts), 0);
    check("R10 block ch2", 32'(rblk), 32'h4);
    rd_en = 1'b1; @(negedge clk);
    check("R9 rd clash", 32'(rd_ts), 0);
    check("R9 wr clash", 32'(wr_ts), 0);
    check("R10 no block clash", 32'(rblk), 0);
    rd_en = 1'b0; wr_en = 1'b0;
    pulse_t2();
    check("R6 hold across t2", 32'(tsel), 1);
    pulse_t0();
    check("R6 close on t0", 32'(tsel), 0);
    pulse_t0();
    check("R4 no open on mismatch", 32'(tsel), 0);
  endtask

  task automatic t_close_despite_match();
    mem_en = 1'b1;
    addr = {2'd1, exp_pos};
    pulse_t0();
    check("R4 open again", 32'(tsel), 1);
    pulse_t0();
    check("R6 close while matching", 32'(tsel), 0);
  endtask

  task automatic t_no_mem();
    mem_en = 1'b0;
    addr = {2'd3, exp_pos};
    pulse_t0();
    check("R5 no open w/o mem", 32'(tsel), 0);
    check("R3 sel off no mem", 32'(chan_sel), 0);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_counter();
    t_decode();
    t_window_gating();
    t_close_despite_match();
    t_no_mem();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule